// File: doc/BRIEF.md
# Interrupt Source Gateway Array

This block sits between raw peripheral interrupt lines and a priority selector. It holds one gateway cell per source. Each cell turns its raw line into a pending bit. A per-source trigger mode decides how the line is read: either as a rising transition or as a sustained high level. A register interface, outside this block, supplies claim and completion strobes. Each strobe carries a source ID, and source index i answers to ID i+1. ID 0 means "no source".

Once a cell raises its pending bit, it marks itself in service and refuses every further event until a completion names its ID. A claim only removes the pending bit. A claim does not end the lockout. A level line that falls while pending does not cancel the request. Edges that arrive while the cell is in service are dropped, and they are not counted. The trigger modes sit in a small register that resets to level mode for every source. The block exports the pending vector and the in-service vector.

Top module: `irq_gateway`

## Requirements
- R1: A source in level mode (mode bit 0) whose line is high while it is not in service shows pending=1 and in_service=1 after the next clock edge.
- R2: A source in edge mode (mode bit 1) raises pending only when its line is 1 at an edge and was 0 at the previous edge. The previous-value register resets to 0. A line held high gives no new event after completion.
- R3: A claim with valid ID i+1 clears pending bit i at the next edge, whatever the line level is. Other pending bits are left alone.
- R4: While in_service[i] is 1, events on source i are ignored. An edge seen in that window is lost for good, even after completion.
- R5: If a level line falls after pending is set, pending stays 1 until claimed.
- R6: A completion with ID i+1 clears in_service[i]. With the line low and no edge, pending stays 0.
- R7: During and after reset, pending and in_service are 0 and every mode bit selects level triggering.
- R8: A claim or completion carrying ID 0 or an ID above NUM_SRC changes no pending or in-service bit.
- R9: An event and a completion for the same source in the same cycle lead to the event being accepted. Pending and in_service are 1 after that edge.
- R10: in_service[i] rises together with pending[i]. A claim does not clear it; only a matching completion does.
- R11: A write of the mode register (cfg_we=1, cfg_edge bit i = 1 for edge) takes effect for event detection from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NUM_SRC | Raw interrupt lines, bit i is ID i+1 |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_edge | input | NUM_SRC | Mode write data, 1 = edge, 0 = level |
| claim_valid | input | 1 | Claim strobe |
| claim_id | input | ID_W | ID being claimed |
| done_valid | input | 1 | Completion strobe |
| done_id | input | ID_W | ID being completed |
| pending | output | NUM_SRC | Pending bits |
| in_service | output | NUM_SRC | Lockout flags per source |

## Verification
Every result of this block appears exactly one clock edge after the cycle that carries its cause. A line level, claim, completion or mode write presented in cycle t shows in pending and in_service after edge t+1. The one exception is the mode register: a mode write only changes detection for events in the following cycle. The bench drives every input just after a falling edge. It compares the outputs at the next falling edge, with directed expectations and with a behavioural model updated on each rising edge. So each check looks at the state produced by exactly one edge.

// File: rtl/irqgw_pkg.sv
package irqgw_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic busy;
        logic prev;
    } gw_state_t;

    localparam gw_state_t GW_RESET = '{pend: 1'b0, busy: 1'b0, prev: 1'b0};

    function automatic logic detect_event(input trig_mode_e mode,
                                          input logic raw,
                                          input logic prev);
        if (mode == TRIG_EDGE) begin
            return raw & ~prev;
        end
        return raw;
    endfunction

endpackage

// File: rtl/irqgw_id_decode.sv
module irqgw_id_decode #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [ID_W-1:0]    id,
    output logic [NUM_SRC-1:0] hit
);

    always_comb begin
        hit = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            hit[i] = valid && (id == ID_W'(i + 1));
        end
    end

    AST_ID_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R8

    AST_ID_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        ((int'(id) > int'(NUM_SRC)) || (id == '0)) |-> (hit == '0)); // R8

endmodule

// File: rtl/irqgw_cell.sv
module irqgw_cell
    import irqgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    input  trig_mode_e mode,
    input  logic       claim_hit,
    input  logic       done_hit,
    output logic       pend,
    output logic       busy
);

    gw_state_t st_q, st_d;
    logic      evt;
    logic      locked;
    logic      accept;

    always_comb begin
        evt    = detect_event(mode, raw, st_q.prev);
        locked = st_q.busy & ~done_hit;
        accept = evt & ~locked;

        st_d      = st_q;
        st_d.prev = raw;
        if (accept) begin
            st_d.pend = 1'b1;
            st_d.busy = 1'b1;
        end else begin
            if (claim_hit) st_d.pend = 1'b0;
            if (done_hit)  st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= GW_RESET;
        else     st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign busy = st_q.busy;

    AST_PEND_NEEDS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        pend |-> busy); // R10

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done_hit) |=> busy); // R4

    AST_CLAIM_DROPS: assert property (@(posedge clk) disable iff (rst)
        (pend && claim_hit && !done_hit) |=> !pend); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend && !claim_hit) |=> pend); // R5

    AST_RISE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(!busy) || $past(done_hit))); // R9

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import irqgw_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic               cfg_we,
    input  logic [NUM_SRC-1:0] cfg_edge,
    input  logic               claim_valid,
    input  logic [ID_W-1:0]    claim_id,
    input  logic               done_valid,
    input  logic [ID_W-1:0]    done_id,
    output logic [NUM_SRC-1:0] pending,
    output logic [NUM_SRC-1:0] in_service
);

    logic [NUM_SRC-1:0] mode_q;
    logic [NUM_SRC-1:0] claim_hit;
    logic [NUM_SRC-1:0] done_hit;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= '0;
        else if (cfg_we) mode_q <= cfg_edge;
    end

    irqgw_id_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_claim_dec (
        .clk  (clk),
        .rst  (rst),
        .valid(claim_valid),
        .id   (claim_id),
        .hit  (claim_hit)
    );

    irqgw_id_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_done_dec (
        .clk  (clk),
        .rst  (rst),
        .valid(done_valid),
        .id   (done_id),
        .hit  (done_hit)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        irqgw_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .raw      (irq_raw[g]),
            .mode     (trig_mode_e'(mode_q[g])),
            .claim_hit(claim_hit[g]),
            .done_hit (done_hit[g]),
            .pend     (pending[g]),
            .busy     (in_service[g])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (pending == '0 && in_service == '0 && mode_q == '0)); // R7

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(mode_q)); // R11

endmodule

// File: tb/irq_gateway_tb_top.sv
`timescale 1ns/1ps
module irq_gateway_tb_top;

    localparam int N  = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_raw = '0;
    logic          cfg_we = 1'b0;
    logic [N-1:0]  cfg_edge = '0;
    logic          claim_valid = 1'b0;
    logic [IW-1:0] claim_id = '0;
    logic          done_valid = 1'b0;
    logic [IW-1:0] done_id = '0;
    logic [N-1:0]  pending;
    logic [N-1:0]  in_service;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_gateway #(.NUM_SRC(N), .ID_W(IW)) dut_i (
        .clk(clk), .rst(rst), .irq_raw(irq_raw), .cfg_we(cfg_we),
        .cfg_edge(cfg_edge), .claim_valid(claim_valid), .claim_id(claim_id),
        .done_valid(done_valid), .done_id(done_id),
        .pending(pending), .in_service(in_service)
    );

    // behavioural reference model
    bit m_pend [N];
    bit m_serv [N];
    bit m_last [N];
    bit m_edge [N];

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_pend[k]) begin
                m_pend[k] = 0; m_serv[k] = 0; m_last[k] = 0; m_edge[k] = 0;
            end
        end else begin
            foreach (m_pend[k]) begin
                bit seen, cl, dn, ok;
                seen = m_edge[k] ? (irq_raw[k] && !m_last[k]) : irq_raw[k];
                cl = claim_valid && (int'(claim_id) == k + 1);
                dn = done_valid && (int'(done_id) == k + 1);
                ok = seen && (!m_serv[k] || dn);
                if (ok) begin
                    m_pend[k] = 1; m_serv[k] = 1;
                end else begin
                    if (cl) m_pend[k] = 0;
                    if (dn) m_serv[k] = 0;
                end
                m_last[k] = irq_raw[k];
            end
            if (cfg_we) foreach (m_edge[k]) m_edge[k] = cfg_edge[k];
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] ep, es;
        cycles++;
        foreach (m_pend[k]) begin
            ep[k] = m_pend[k];
            es[k] = m_serv[k];
        end
        checks++;
        if (pending !== ep || in_service !== es) begin
            failures++;
            $display("FAIL model compare: pending=%h in_service=%h expected %h %h",
                     pending, in_service, ep, es);
        end
        if (cycles > 20000 && !finished) begin
            failures++;
            $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
        #0.1;
    endtask

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic claim(input int id);
        claim_valid = 1'b1; claim_id = IW'(id);
        tick();
        claim_valid = 1'b0; claim_id = '0;
    endtask

    task automatic done(input int id);
        done_valid = 1'b1; done_id = IW'(id);
        tick();
        done_valid = 1'b0; done_id = '0;
    endtask

    task automatic write_mode(input logic [N-1:0] m);
        cfg_we = 1'b1; cfg_edge = m;
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        irq_raw = 8'h40;
        repeat (3) tick();
        chk("R7 pending in reset", pending, 8'h00);
        chk("R7 in_service in reset", in_service, 8'h00);
        rst = 1'b0;
        tick();
        chk("R7 level mode after reset", pending, 8'h40);
        chk("R10 in_service with pending", in_service, 8'h40);

        claim(7);
        chk("R3 claim clears while line high", pending, 8'h00);
        chk("R10 claim keeps in_service", in_service, 8'h40);

        irq_raw = 8'h41; tick();
        chk("R1 level event and R4 lockout", pending, 8'h01);
        chk("R1 in_service", in_service, 8'h41);
        irq_raw = 8'h40; tick();
        chk("R5 dropped level keeps pending", pending, 8'h01);

        done(7);
        chk("R6 R9 completion re-arms high level", pending, 8'h41);
        claim(1); claim(7);
        irq_raw = 8'h00;
        done(1); done(7);
        chk("R6 completion with low line", pending, 8'h00);
        chk("R6 in_service cleared", in_service, 8'h00);

        write_mode(8'h02);
        irq_raw = 8'h02; tick();
        chk("R2 R11 edge event", pending, 8'h02);
        claim(2); done(2);
        chk("R2 held line gives no new event", pending, 8'h00);
        chk("R2 in_service idle", in_service, 8'h00);

        write_mode(8'h00);
        chk("R11 write cycle uses old mode", pending, 8'h00);
        tick();
        chk("R11 level mode after write", pending, 8'h02);
        claim(2);
        irq_raw = 8'h00;
        done(2);

        write_mode(8'h04);
        irq_raw = 8'h04; tick();
        chk("R2 edge on source 2", pending, 8'h04);
        irq_raw = 8'h00; tick();
        claim(3);
        irq_raw = 8'h04; tick();
        chk("R4 edge while in service", pending, 8'h00);
        irq_raw = 8'h00; tick();
        done(3);
        chk("R4 lost edge not replayed", pending, 8'h00);
        chk("R4 in_service cleared", in_service, 8'h00);
        irq_raw = 8'h04; tick();
        chk("R2 fresh edge accepted", pending, 8'h04);

        claim(0); claim(9); claim(15);
        chk("R8 bad claim ids ignored", pending, 8'h04);
        done(0); done(9); done(15);
        chk("R8 bad completion ids ignored", in_service, 8'h04);

        claim(3);
        irq_raw = 8'h00; tick();
        irq_raw = 8'h04;
        done(3);
        chk("R9 same-cycle edge and completion", pending, 8'h04);
        chk("R9 in_service set", in_service, 8'h04);

        irq_raw = 8'hFC; tick();
        chk("R1 several level sources", pending, 8'hFC);
        claim(5);
        chk("R3 claim touches one source", pending, 8'hEC);
        chk("R10 in_service kept", in_service, 8'hFC);

        rst = 1'b1; tick();
        chk("R7 reset clears pending", pending, 8'h00);
        chk("R7 reset clears in_service", in_service, 8'h00);

        finish_run();
    end

endmodule